// File: doc/BRIEF.md
# Speculative Line Tracker for Lock Elision

This block is the tag-side controller of a small direct-mapped L1 data cache that runs critical sections speculatively instead of taking the lock. While a region is open, every line the core loads from gets a read mark, and every line it stores to gets a write mark. Incoming coherence snoops are compared against those marks. A clash closes the region, throws the speculative work away and tells the core to restore its register checkpoint and replay from the region entry.

Speculative store data goes straight into the L1 data array, which the surrounding logic holds. The next cache level keeps the pre-speculation copy. To make that copy safe, a line that is already dirty is written back before it takes its first speculative store.

A commit clears every mark in one cycle, and the stored data simply becomes architectural. An abort invalidates every write-marked line in one cycle, so that later loads miss and fetch the old value from the next level. The data array, the fill path and the choice of which thread wins a conflict live outside this block.

Top module: `spec_track_l1`

## Requirements
- R1: After reset no region is open, no writeback is pending, the abort and restore outputs are low, and every line is invalid, so the first load to any address responds with rsp_hit=0.
- R2: A load accepted while a region is open marks its line as speculatively read. A later remote read snoop (snp_inv=0) to that line raises no conflict. A remote invalidate snoop (snp_inv=1) to it raises conflict_abort and restore_ckpt on the cycle after the snoop.
- R3: A store marks its line as speculatively written when a region is open, and it always leaves the line dirty and exclusive. Its response has rsp_own=1 unless the line was already held exclusive on a hit. A remote read snoop to a write-marked line raises conflict_abort on the cycle after the snoop.
- R4: The first speculative store to a dirty line without a write mark is not accepted at first. Instead wb_valid rises with wb_addr equal to the line address, and it holds until wb_ack. Only after that is the store accepted. Further speculative stores to the same line cause no writeback.
- R5: spec_commit in an open region closes it on the next cycle and clears every mark at once. Committed lines stay valid and hit, and later snoops to them raise no conflict.
- R6: An abort clears in_region on the next cycle and gives restore_ckpt as a one-cycle pulse on that cycle. The abort can come from spec_abort, a conflict or an overflow. In the same cycle every write-marked line is invalidated (a later load misses), while lines that were only read-marked stay valid (a later load hits). spec_abort alone gives conflict_abort=0.
- R7: Outside a region, snoops never raise an abort. A remote read removes exclusivity, so a later store reports rsp_own=1. A remote invalidate makes the next load to that line miss.
- R8: A request that misses and whose victim line carries a mark is not accepted in that cycle. Instead overflow_abort and restore_ckpt pulse on the next cycle, and the retried request is accepted afterwards. conflict_abort and overflow_abort are never high together.
- R9: A miss whose victim line is valid and dirty first writes back the victim. wb_addr is {victim tag, index}, and the line index is the low $clog2(LINES) bits of an address. The request is accepted after wb_ack.
- R10: The core is stalled (cpu_ready=0) in any cycle with snp_valid, spec_begin, spec_commit or spec_abort, and while a writeback is pending. An abort wins over a commit in the same cycle. spec_begin inside a region is ignored (regions do not nest), and spec_commit or spec_abort outside a region has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cpu_valid | input | 1 | Core request present; held until cpu_ready |
| cpu_we | input | 1 | 1 = store, 0 = load |
| cpu_addr | input | AW | Line address of the request |
| cpu_ready | output | 1 | Request accepted this cycle |
| rsp_valid | output | 1 | Response for the request accepted last cycle |
| rsp_hit | output | 1 | That request hit a valid line |
| rsp_own | output | 1 | That store needed ownership (miss or shared line) |
| spec_begin | input | 1 | Open a speculative region |
| spec_commit | input | 1 | Commit the open region |
| spec_abort | input | 1 | Software abort of the open region |
| in_region | output | 1 | A speculative region is open |
| snp_valid | input | 1 | Remote snoop present |
| snp_inv | input | 1 | 1 = remote write/invalidate, 0 = remote read |
| snp_addr | input | AW | Line address of the snoop |
| wb_valid | output | 1 | Writeback of a dirty line requested |
| wb_addr | output | AW | Line address being written back |
| wb_ack | input | 1 | Next level has taken the writeback |
| conflict_abort | output | 1 | Pulse: region aborted by a snoop conflict |
| overflow_abort | output | 1 | Pulse: region aborted by eviction of a marked line |
| restore_ckpt | output | 1 | Pulse: restore the register checkpoint and replay |

## Verification
The bench targets the writeback-before-first-store ordering. A design that set the write mark early, or that skipped the clean, would accept the store with no wb_valid pulse, or would repeat the writeback on every later store. It drives a remote read and a remote invalidate against read-only and written lines, inside and outside a region. A design with the conflict rules swapped, or with conflict checking left on after commit, would abort when it should not, or miss a real conflict. After each kind of abort it probes lines with loads, so a flash that invalidated read-only lines too, or no lines at all, shows up in rsp_hit. It also evicts a marked line and fires a snoop conflict together with a commit, which exposes a lost overflow and a wrong priority between abort and commit.

// File: rtl/spec_trk_pkg.sv
package spec_trk_pkg;

  typedef struct packed {
    logic valid;
    logic dirty;
    logic excl;
    logic rmark;
    logic wmark;
  } line_flags_t;

  // state after an accepted core access
  function automatic line_flags_t core_update(line_flags_t f, logic hit, logic we, logic spec);
    line_flags_t n;
    n = hit ? f : '0;
    n.valid = 1'b1;
    if (we) begin
      n.dirty = 1'b1;
      n.excl  = 1'b1;
      n.wmark = n.wmark | spec;
    end else begin
      n.rmark = n.rmark | spec;
    end
    return n;
  endfunction

  // state after a remote snoop hits the line
  function automatic line_flags_t snoop_update(line_flags_t f, logic inv);
    line_flags_t n;
    n = f;
    if (inv) n = '0;
    else     n.excl = 1'b0;
    return n;
  endfunction

  // region-wide flash operations
  function automatic line_flags_t flash_update(line_flags_t f, logic commit, logic abort);
    line_flags_t n;
    n = f;
    if (abort) begin
      if (f.wmark) begin
        n.valid = 1'b0;
        n.dirty = 1'b0;
        n.excl  = 1'b0;
      end
      n.rmark = 1'b0;
      n.wmark = 1'b0;
    end else if (commit) begin
      n.rmark = 1'b0;
      n.wmark = 1'b0;
    end
    return n;
  endfunction

  function automatic logic snoop_clash(line_flags_t f, logic inv);
    return inv ? (f.rmark | f.wmark) : f.wmark;
  endfunction

  function automatic logic needs_clean(line_flags_t f, logic hit, logic we, logic spec);
    return we && spec && hit && f.dirty && !f.wmark;
  endfunction

endpackage

// File: rtl/spec_line_store.sv
module spec_line_store
  import spec_trk_pkg::*;
#(
  parameter int LINES = 8,
  parameter int TAGW  = 5,
  localparam int IDXW = $clog2(LINES)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [IDXW-1:0] a_idx,
  output line_flags_t     a_flags,
  output logic [TAGW-1:0] a_tag,
  input  logic [IDXW-1:0] b_idx,
  output line_flags_t     b_flags,
  output logic [TAGW-1:0] b_tag,
  input  logic            core_wr,
  input  logic [IDXW-1:0] core_idx,
  input  logic [TAGW-1:0] core_tag,
  input  line_flags_t     core_flags,
  input  logic            snp_upd,
  input  logic [IDXW-1:0] snp_idx,
  input  logic            snp_inv,
  input  logic            clean_en,
  input  logic [IDXW-1:0] clean_idx,
  input  logic            flash_commit,
  input  logic            flash_abort
);

  line_flags_t     fl [LINES];
  logic [TAGW-1:0] tg [LINES];

  assign a_flags = fl[a_idx];
  assign a_tag   = tg[a_idx];
  assign b_flags = fl[b_idx];
  assign b_tag   = tg[b_idx];

  for (genvar i = 0; i < LINES; i++) begin : g_line
    line_flags_t nxt;
    always_comb begin
      nxt = fl[i];
      if (clean_en && clean_idx == IDXW'(i)) nxt.dirty = 1'b0;
      if (snp_upd && snp_idx == IDXW'(i))    nxt = snoop_update(nxt, snp_inv);
      nxt = flash_update(nxt, flash_commit, flash_abort);
      if (core_wr && core_idx == IDXW'(i))   nxt = core_flags;
    end
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        fl[i] <= '0;
        tg[i] <= '0;
      end else begin
        fl[i] <= nxt;
        if (core_wr && core_idx == IDXW'(i)) tg[i] <= core_tag;
      end
    end
  end

endmodule

// File: rtl/spec_snoop_check.sv
module spec_snoop_check
  import spec_trk_pkg::*;
#(
  parameter int TAGW = 5
) (
  input  logic            snp_valid,
  input  logic            snp_inv,
  input  logic [TAGW-1:0] snp_tag,
  input  line_flags_t     line_f,
  input  logic [TAGW-1:0] line_tag,
  input  logic            region,
  output logic            snp_hit,
  output logic            clash
);

  assign snp_hit = snp_valid && line_f.valid && (line_tag == snp_tag);
  assign clash   = region && snp_hit && snoop_clash(line_f, snp_inv);

endmodule

// File: rtl/spec_clean_fsm.sv
module spec_clean_fsm #(
  parameter int AW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [AW-1:0] start_addr,
  input  logic          wb_ack,
  output logic          wb_valid,
  output logic [AW-1:0] wb_addr,
  output logic          done
);

  typedef enum logic {WB_IDLE, WB_WAIT} wb_state_t;
  wb_state_t st;

  assign wb_valid = (st == WB_WAIT);
  assign done     = wb_valid && wb_ack;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st      <= WB_IDLE;
      wb_addr <= '0;
    end else if (st == WB_IDLE) begin
      if (start) begin
        st      <= WB_WAIT;
        wb_addr <= start_addr;
      end
    end else if (wb_ack) begin
      st <= WB_IDLE;
    end
  end

endmodule

// File: rtl/spec_track_l1.sv
module spec_track_l1
  import spec_trk_pkg::*;
#(
  parameter int LINES = 8,
  parameter int AW    = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cpu_valid,
  input  logic          cpu_we,
  input  logic [AW-1:0] cpu_addr,
  output logic          cpu_ready,
  output logic          rsp_valid,
  output logic          rsp_hit,
  output logic          rsp_own,
  input  logic          spec_begin,
  input  logic          spec_commit,
  input  logic          spec_abort,
  output logic          in_region,
  input  logic          snp_valid,
  input  logic          snp_inv,
  input  logic [AW-1:0] snp_addr,
  output logic          wb_valid,
  output logic [AW-1:0] wb_addr,
  input  logic          wb_ack,
  output logic          conflict_abort,
  output logic          overflow_abort,
  output logic          restore_ckpt
);

  localparam int IDXW = $clog2(LINES);
  localparam int TAGW = AW - IDXW;

  logic [IDXW-1:0] c_idx, s_idx;
  logic [TAGW-1:0] c_tag, s_tag, c_ltag, s_ltag;
  line_flags_t     c_f, s_f, c_new;
  logic            region_q;

  assign c_idx = cpu_addr[IDXW-1:0];
  assign c_tag = cpu_addr[AW-1:IDXW];
  assign s_idx = snp_addr[IDXW-1:0];
  assign s_tag = snp_addr[AW-1:IDXW];

  // named internal events
  logic c_hit, ctrl_cycle, base_ok, overflow_ev, clean_ev, evict_ev;
  logic wb_start, accept, snp_hit, conflict_ev, abort_ev, commit_ev, wb_done;
  logic [AW-1:0] wb_start_addr;

  assign c_hit       = c_f.valid && (c_ltag == c_tag);
  assign ctrl_cycle  = snp_valid || spec_begin || spec_commit || spec_abort;
  assign base_ok     = cpu_valid && !ctrl_cycle && !wb_valid;
  assign overflow_ev = base_ok && !c_hit && c_f.valid && (c_f.rmark || c_f.wmark);
  assign clean_ev    = base_ok && needs_clean(c_f, c_hit, cpu_we, region_q);
  assign evict_ev    = base_ok && !c_hit && c_f.valid && c_f.dirty;
  assign wb_start    = !overflow_ev && (clean_ev || evict_ev);
  assign accept      = base_ok && !overflow_ev && !clean_ev && !evict_ev;
  assign wb_start_addr = c_hit ? cpu_addr : {c_ltag, c_idx};
  assign abort_ev    = region_q && (spec_abort || conflict_ev || overflow_ev);
  assign commit_ev   = region_q && spec_commit && !abort_ev;
  assign c_new       = core_update(c_f, c_hit, cpu_we, region_q);

  assign cpu_ready = accept;
  assign in_region = region_q;

  spec_line_store #(.LINES(LINES), .TAGW(TAGW)) u_store (
    .clk(clk), .rst_n(rst_n),
    .a_idx(c_idx), .a_flags(c_f), .a_tag(c_ltag),
    .b_idx(s_idx), .b_flags(s_f), .b_tag(s_ltag),
    .core_wr(accept), .core_idx(c_idx), .core_tag(c_tag), .core_flags(c_new),
    .snp_upd(snp_hit), .snp_idx(s_idx), .snp_inv(snp_inv),
    .clean_en(wb_done), .clean_idx(wb_addr[IDXW-1:0]),
    .flash_commit(commit_ev), .flash_abort(abort_ev)
  );

  spec_snoop_check #(.TAGW(TAGW)) u_snoop (
    .snp_valid(snp_valid), .snp_inv(snp_inv), .snp_tag(s_tag),
    .line_f(s_f), .line_tag(s_ltag), .region(region_q),
    .snp_hit(snp_hit), .clash(conflict_ev)
  );

  spec_clean_fsm #(.AW(AW)) u_clean (
    .clk(clk), .rst_n(rst_n),
    .start(wb_start), .start_addr(wb_start_addr), .wb_ack(wb_ack),
    .wb_valid(wb_valid), .wb_addr(wb_addr), .done(wb_done)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      region_q       <= 1'b0;
      rsp_valid      <= 1'b0;
      rsp_hit        <= 1'b0;
      rsp_own        <= 1'b0;
      conflict_abort <= 1'b0;
      overflow_abort <= 1'b0;
      restore_ckpt   <= 1'b0;
    end else begin
      if (abort_ev || commit_ev)       region_q <= 1'b0;
      else if (!region_q && spec_begin) region_q <= 1'b1;
      rsp_valid      <= accept;
      rsp_hit        <= c_hit;
      rsp_own        <= cpu_we && !(c_hit && c_f.excl);
      conflict_abort <= conflict_ev;
      overflow_abort <= overflow_ev;
      restore_ckpt   <= abort_ev;
    end
  end

endmodule

// File: rtl/spec_track_l1_chk.sv
module spec_track_l1_chk #(
  parameter int AW = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic          cpu_ready,
  input logic          rsp_valid,
  input logic          spec_commit,
  input logic          in_region,
  input logic          snp_valid,
  input logic          wb_valid,
  input logic          wb_ack,
  input logic [AW-1:0] wb_addr,
  input logic          conflict_abort,
  input logic          overflow_abort,
  input logic          restore_ckpt,
  input logic          overflow_ev
);

  AST_WB_STALLS: assert property (@(posedge clk) disable iff (!rst_n)
    wb_valid |-> !cpu_ready); // R4

  AST_WB_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (wb_valid && !wb_ack) |=> (wb_valid && $stable(wb_addr))); // R9

  AST_RSP_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_ready |=> rsp_valid); // R2

  AST_CONFLICT_RESTORE: assert property (@(posedge clk) disable iff (!rst_n)
    conflict_abort |-> (restore_ckpt && !in_region)); // R6

  AST_RESTORE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    restore_ckpt |=> !restore_ckpt); // R6

  AST_CAUSE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({conflict_abort, overflow_abort})); // R8

  AST_OVF_NO_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
    overflow_ev |-> !cpu_ready); // R8

  AST_NO_CONFLICT_OUTSIDE: assert property (@(posedge clk) disable iff (!rst_n)
    !in_region |=> !conflict_abort); // R7

  AST_COMMIT_CLOSES: assert property (@(posedge clk) disable iff (!rst_n)
    (in_region && spec_commit) |=> !in_region); // R5

  AST_SNOOP_STALL: assert property (@(posedge clk) disable iff (!rst_n)
    snp_valid |-> !cpu_ready); // R10

endmodule

bind spec_track_l1 spec_track_l1_chk #(.AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .cpu_ready(cpu_ready), .rsp_valid(rsp_valid),
  .spec_commit(spec_commit), .in_region(in_region), .snp_valid(snp_valid),
  .wb_valid(wb_valid), .wb_ack(wb_ack), .wb_addr(wb_addr),
  .conflict_abort(conflict_abort), .overflow_abort(overflow_abort),
  .restore_ckpt(restore_ckpt), .overflow_ev(overflow_ev)
);

// File: tb/test_spec_track_l1.sv
module test_spec_track_l1;

  localparam int L  = 8;
  localparam int AW = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cpu_valid = 0, cpu_we = 0, spec_begin = 0, spec_commit = 0, spec_abort = 0;
  logic snp_valid = 0, snp_inv = 0, wb_ack = 0;
  logic [AW-1:0] cpu_addr = '0, snp_addr = '0;
  logic cpu_ready, rsp_valid, rsp_hit, rsp_own, in_region, wb_valid;
  logic conflict_abort, overflow_abort, restore_ckpt;
  logic [AW-1:0] wb_addr;

  always #10 clk = ~clk;

  spec_track_l1 #(.LINES(L), .AW(AW)) i_spec_track_l1 (
    .clk(clk), .rst_n(rst_n), .cpu_valid(cpu_valid), .cpu_we(cpu_we), .cpu_addr(cpu_addr),
    .cpu_ready(cpu_ready), .rsp_valid(rsp_valid), .rsp_hit(rsp_hit), .rsp_own(rsp_own),
    .spec_begin(spec_begin), .spec_commit(spec_commit), .spec_abort(spec_abort),
    .in_region(in_region), .snp_valid(snp_valid), .snp_inv(snp_inv), .snp_addr(snp_addr),
    .wb_valid(wb_valid), .wb_addr(wb_addr), .wb_ack(wb_ack),
    .conflict_abort(conflict_abort), .overflow_abort(overflow_abort), .restore_ckpt(restore_ckpt)
  );

  int checks = 0, errors = 0, wbcnt = 0, cycles = 0;
  bit done_flag = 0;

  // behavioural reference: per-index line records
  bit mv[L], md[L], me[L], mr[L], mw[L];
  int mt[L];
  bit m_region, m_busy, m_rv, m_rh, m_ro, m_ca, m_oa, m_rc, m_acc;
  int m_wbaddr;
  // scenario observations
  bit saw_wb, saw_ovf;
  int seen_wb_addr;

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic model_eval();
    int ci, ct, si, st;
    bit ctrl, hit, ovf, cln, evw, base, shit, conf, abrt;
    ci = int'(cpu_addr) % L; ct = int'(cpu_addr) / L;
    si = int'(snp_addr) % L; st = int'(snp_addr) / L;
    ctrl = snp_valid | spec_begin | spec_commit | spec_abort;
    hit  = mv[ci] && (mt[ci] == ct);
    base = cpu_valid && !ctrl && !m_busy;
    ovf  = base && !hit && mv[ci] && (mr[ci] || mw[ci]);
    cln  = cpu_we && m_region && hit && md[ci] && !mw[ci];
    evw  = !hit && mv[ci] && md[ci];
    m_acc = base && !ovf && !cln && !evw;
    chk("R10 cpu_ready", int'(cpu_ready), int'(m_acc));
    shit = snp_valid && mv[si] && (mt[si] == st);
    conf = m_region && shit && (snp_inv ? (mr[si] || mw[si]) : mw[si]);
    abrt = m_region && (spec_abort || conf || ovf);
    m_rv = m_acc; m_rh = hit; m_ro = cpu_we && !(hit && me[ci]);
    m_ca = conf; m_oa = ovf; m_rc = abrt;
    if (m_busy) begin
      if (wb_ack) begin md[m_wbaddr % L] = 0; m_busy = 0; end
    end else if (base && !ovf && (cln || evw)) begin
      m_busy = 1;
      m_wbaddr = hit ? int'(cpu_addr) : mt[ci] * L + ci;
    end
    if (shit) begin
      if (snp_inv) begin mv[si] = 0; md[si] = 0; me[si] = 0; mr[si] = 0; mw[si] = 0; end
      else me[si] = 0;
    end
    for (int i = 0; i < L; i++) begin
      if (abrt) begin
        if (mw[i]) begin mv[i] = 0; md[i] = 0; me[i] = 0; end
        mr[i] = 0; mw[i] = 0;
      end else if (m_region && spec_commit) begin
        mr[i] = 0; mw[i] = 0;
      end
    end
    if (m_acc) begin
      if (!hit) begin md[ci] = 0; me[ci] = 0; mr[ci] = 0; mw[ci] = 0; end
      mv[ci] = 1; mt[ci] = ct;
      if (cpu_we) begin md[ci] = 1; me[ci] = 1; if (m_region) mw[ci] = 1; end
      else if (m_region) mr[ci] = 1;
    end
    if (abrt || (m_region && spec_commit)) m_region = 0;
    else if (!m_region && spec_begin) m_region = 1;
  endtask

  task automatic step();
    if (wb_valid) wbcnt++; else wbcnt = 0;
    wb_ack = (wbcnt >= 2);
    #1;
    model_eval();
    @(posedge clk);
    @(negedge clk);
    chk("R2 rsp_valid", int'(rsp_valid), int'(m_rv));
    if (m_rv) begin
      chk("R2 rsp_hit", int'(rsp_hit), int'(m_rh));
      chk("R3 rsp_own", int'(rsp_own), int'(m_ro));
    end
    chk("R4 wb_valid", int'(wb_valid), int'(m_busy));
    if (m_busy) chk("R9 wb_addr", int'(wb_addr), m_wbaddr);
    chk("R3 conflict_abort", int'(conflict_abort), int'(m_ca));
    chk("R8 overflow_abort", int'(overflow_abort), int'(m_oa));
    chk("R6 restore_ckpt", int'(restore_ckpt), int'(m_rc));
    chk("R5 in_region", int'(in_region), int'(m_region));
    if (wb_valid) begin saw_wb = 1; seen_wb_addr = int'(wb_addr); end
    if (overflow_abort) saw_ovf = 1;
  endtask

  task automatic req(bit we, int addr);
    saw_wb = 0; saw_ovf = 0;
    cpu_valid = 1; cpu_we = we; cpu_addr = AW'(addr);
    for (int k = 0; k < 20; k++) begin
      step();
      if (m_acc) break;
    end
    cpu_valid = 0; cpu_we = 0;
  endtask

  task automatic snoop(bit inv, int addr);
    snp_valid = 1; snp_inv = inv; snp_addr = AW'(addr);
    step();
    snp_valid = 0; snp_inv = 0;
  endtask

  task automatic ctl(bit b, bit c, bit a);
    spec_begin = b; spec_commit = c; spec_abort = a;
    step();
    spec_begin = 0; spec_commit = 0; spec_abort = 0;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000 && !done_flag) begin
      done_flag = 1;
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < L; i++) begin mv[i] = 0; md[i] = 0; me[i] = 0; mr[i] = 0; mw[i] = 0; mt[i] = 0; end
    m_region = 0; m_busy = 0; m_wbaddr = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R1 reset state
    chk("R1 in_region", int'(in_region), 0);
    chk("R1 wb_valid", int'(wb_valid), 0);
    chk("R1 restore_ckpt", int'(restore_ckpt), 0);
    chk("R1 conflict_abort", int'(conflict_abort), 0);
    req(0, 'h11); chk("R1 first load misses", int'(rsp_hit), 0);
    req(0, 'h11); chk("R2 reload hits", int'(rsp_hit), 1);
    req(1, 'h11); chk("R3 store to shared line needs ownership", int'(rsp_own), 1);
    req(1, 'h11); chk("R3 store to exclusive line", int'(rsp_own), 0);
    // R4 clean before first speculative store
    ctl(1, 0, 0); chk("R5 region open", int'(in_region), 1);
    req(1, 'h11);
    chk("R4 clean writeback seen", int'(saw_wb), 1);
    chk("R4 clean address", seen_wb_addr, 'h11);
    req(1, 'h11); chk("R4 no second writeback", int'(saw_wb), 0);
    req(0, 'h22); chk("R2 spec load miss", int'(rsp_hit), 0);
    snoop(0, 'h22); chk("R2 remote read on read line no conflict", int'(conflict_abort), 0);
    snoop(0, 'h12); chk("R2 other tag no conflict", int'(conflict_abort), 0);
    // R5 commit
    ctl(0, 1, 0); chk("R5 commit closes region", int'(in_region), 0);
    chk("R5 commit no restore", int'(restore_ckpt), 0);
    req(0, 'h11); chk("R5 committed line hits", int'(rsp_hit), 1);
    snoop(1, 'h22); chk("R7 snoop outside region no conflict", int'(conflict_abort), 0);
    req(0, 'h22); chk("R7 invalidated line misses", int'(rsp_hit), 0);
    snoop(0, 'h11); chk("R7 remote read outside region", int'(restore_ckpt), 0);
    req(1, 'h11); chk("R7 exclusivity removed", int'(rsp_own), 1);
    // R2 / R6 conflict on read mark
    ctl(1, 0, 0);
    req(0, 'h33);
    snoop(1, 'h33);
    chk("R2 invalidate on read line conflicts", int'(conflict_abort), 1);
    chk("R6 restore after conflict", int'(restore_ckpt), 1);
    chk("R6 region closed", int'(in_region), 0);
    step(); chk("R6 restore is a pulse", int'(restore_ckpt), 0);
    // R6 software abort
    ctl(1, 0, 0);
    req(1, 'h44);
    req(0, 'h55);
    ctl(0, 0, 1);
    chk("R6 software abort restore", int'(restore_ckpt), 1);
    chk("R6 software abort not a conflict", int'(conflict_abort), 0);
    req(0, 'h44); chk("R6 written line invalidated", int'(rsp_hit), 0);
    req(0, 'h55); chk("R6 read line kept", int'(rsp_hit), 1);
    // R3 remote read on written line
    ctl(1, 0, 0);
    req(1, 'h2C);
    snoop(0, 'h2C); chk("R3 remote read on written line conflicts", int'(conflict_abort), 1);
    // R8 overflow
    ctl(1, 0, 0);
    req(0, 'h66);
    req(0, 'h0E);
    chk("R8 overflow abort seen", int'(saw_ovf), 1);
    chk("R8 region closed by overflow", int'(in_region), 0);
    chk("R8 retried request misses", int'(rsp_hit), 0);
    // R9 dirty eviction
    req(1, 'h07);
    req(0, 'h0F);
    chk("R9 victim writeback seen", int'(saw_wb), 1);
    chk("R9 victim address", seen_wb_addr, 'h07);
    // R10 abort beats commit, snoop stalls core
    ctl(1, 0, 0);
    req(0, 'h2A);
    cpu_valid = 1; cpu_addr = AW'('h2A); spec_commit = 1;
    snp_valid = 1; snp_inv = 1; snp_addr = AW'('h2A);
    #1; chk("R10 core stalled by snoop", int'(cpu_ready), 0);
    step();
    cpu_valid = 0; spec_commit = 0; snp_valid = 0; snp_inv = 0;
    chk("R10 abort wins over commit", int'(conflict_abort), 1);
    chk("R10 restore on abort", int'(restore_ckpt), 1);
    // R10 ignored controls
    ctl(0, 1, 0); chk("R10 commit outside region ignored", int'(restore_ckpt), 0);
    ctl(0, 0, 1); chk("R10 abort outside region ignored", int'(restore_ckpt), 0);
    ctl(1, 0, 0);
    ctl(1, 0, 0); chk("R10 nested begin keeps region", int'(in_region), 1);
    ctl(0, 1, 0); chk("R10 single commit closes flat region", int'(in_region), 0);
    repeat (3) step();
    if (!done_flag) begin
      done_flag = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule